// File: doc/BRIEF.md
# Normalizing Shifter with Subnormal Floor

This block sits between an arithmetic datapath and a rounder. It accepts an intermediate floating-point result as a sign bit, a signed exponent and an unsigned fixed-point magnitude. The magnitude has two integer bits, so it may be anywhere from zero up to just under four, and it may carry leading zeros. The block moves the leading one onto the units position and adjusts the exponent to match. If the magnitude is two or more, it shifts right by one place. If it is below one, it shifts left.

A left shift never takes the exponent below the minimum exponent EMIN. When the leading-zero count is larger than the exponent's headroom above EMIN, the shift stops at the headroom. The exponent then equals EMIN and the significand stays below one, which is the subnormal case. The significand is cut to FRAC_OUT fraction bits. Every bit cut away, including the bit lost in a right shift, is ORed into a single sticky bit. The truncated significand and the sticky bit together tell a rounder which interval the exact value lies in, or that the value sits exactly on a grid point.

The computation is combinational and the result is registered, so it is due one clock after the input is presented. The caller must keep the input exponent at EMIN or above. For inputs of two or more, it must also leave room for the exponent to rise by one.

Top module: `norm_clamp`

## Requirements
- R1: While rst_n is low, and after it is released until the first valid input, out_valid is 0 and out_sig, out_exp and out_sticky are 0.
- R2: An input presented with in_valid high at a rising clock edge appears on the outputs after that edge, with out_valid high. This allows one result per cycle.
- R3: If the input magnitude is at least 2^EMIN, bit 8 of out_sig (the units bit) is 1. out_sig[7:0] holds the fraction, so the significand lies in [1,2).
- R4: If the input magnitude is below 2^EMIN, out_exp equals EMIN and bit 8 of out_sig is 0, so the significand lies in [0,1).
- R5: If in_mag[15] is 0, the magnitude is shifted left by min(leading-zero count of in_mag[14:0], in_exp - EMIN). The exponent is reduced by that same amount, so the value is unchanged.
- R6: If in_mag[15] is 1 (magnitude in [2,4)), the magnitude is shifted right by one place and out_exp = in_exp + 1. The bit in_mag[0] that is shifted out is ORed into out_sticky.
- R7: in_mag[15:14] are integer bits and in_mag[13:0] are fraction bits. After shifting, the units bit and the top 8 fraction bits form out_sig[8:0]. out_sticky is the OR of every lower bit that was discarded.
- R8: A zero magnitude yields out_exp = EMIN, out_sig = 0 and out_sticky = 0, whatever the input exponent.
- R9: out_sign equals the in_sign that was captured, including for a zero magnitude.
- R10: A cycle with in_valid low leaves out_sign, out_exp, out_sig and out_sticky unchanged and drives out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Captures the input on this edge |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EXP_W | Signed exponent, EMIN or above |
| in_mag | input | MAG_W | Magnitude: 2 integer bits, MAG_W-2 fraction bits |
| out_valid | output | 1 | Result registered this cycle |
| out_sign | output | 1 | Sign, passed through unchanged |
| out_exp | output | EXP_W | Signed exponent after normalization, never below EMIN |
| out_sig | output | FRAC_OUT+1 | Significand: 1 units bit above FRAC_OUT fraction bits |
| out_sticky | output | 1 | OR of all discarded magnitude bits |

## Verification
Every result, including the sticky bit and the valid flag, is due at the first rising edge after the input is captured. Nothing in the block takes more than one cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. This includes back-to-back inputs, where it samples the previous result before it drives the next one. The hold case is checked in the same way: the bench drives changed data with in_valid low, lets one edge pass, and then compares the outputs with the earlier result.

// File: rtl/nrm_pkg.sv
`timescale 1ns/1ps
package nrm_pkg;

  // Which way the magnitude moves to reach the units position.
  typedef enum logic {
    MOVE_LEFT  = 1'b0,
    MOVE_RIGHT = 1'b1
  } move_dir_e;

endpackage

// File: rtl/nrm_lzc.sv
`timescale 1ns/1ps
// Leading-zero count of a W-bit vector; an all-zero vector counts W.
module nrm_lzc #(
  parameter int W  = 15,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  always_comb begin
    zeros = CW'(W);
    // Scan upward so the highest set bit is the last one to assign.
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/nrm_shamt.sv
`timescale 1ns/1ps
// Chooses the move direction, the left-shift amount limited by the
// headroom above EMIN, and the exponent that goes with them.
module nrm_shamt
  import nrm_pkg::*;
#(
  parameter int EXP_W = 10,
  parameter int CW    = 4,
  parameter int EMIN  = -126
) (
  input  logic                    mag_big,
  input  logic                    mag_zero,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [CW-1:0]           lead_zeros,
  output move_dir_e               dir,
  output logic [CW-1:0]           shamt,
  output logic signed [EXP_W-1:0] exp_out
);

  localparam int XW = EXP_W + 1;
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);

  logic signed [XW-1:0] headroom;
  logic signed [XW-1:0] lz_x;

  always_comb begin
    headroom = XW'(exp_in) - EMIN_X;
    lz_x     = XW'({1'b0, lead_zeros});

    // Left shift limited by the headroom; negative headroom means no shift.
    if (headroom < 0)
      shamt = '0;
    else if (headroom < lz_x)
      shamt = headroom[CW-1:0];
    else
      shamt = lead_zeros;

    if (mag_big) begin
      dir     = MOVE_RIGHT;
      exp_out = exp_in + EXP_W'(1);
    end else if (mag_zero) begin
      dir     = MOVE_LEFT;
      exp_out = EXP_W'(EMIN);
    end else begin
      dir     = MOVE_LEFT;
      exp_out = exp_in - EXP_W'({1'b0, shamt});
    end
  end

endmodule

// File: rtl/nrm_align.sv
`timescale 1ns/1ps
// Moves the magnitude, keeps SIG_W bits and folds the rest into sticky.
module nrm_align
  import nrm_pkg::*;
#(
  parameter int MAG_W = 16,
  parameter int SIG_W = 9,
  parameter int CW    = 4
) (
  input  logic [MAG_W-1:0] mag,
  input  move_dir_e        dir,
  input  logic [CW-1:0]    shamt,
  output logic [SIG_W-1:0] sig,
  output logic             sticky
);

  localparam int W      = MAG_W - 1;
  localparam int DROP_W = W - SIG_W;

  logic [W-1:0] moved;
  logic         lost_bit;

  always_comb begin
    if (dir == MOVE_RIGHT) begin
      moved    = mag[MAG_W-1:1];
      lost_bit = mag[0];
    end else begin
      moved    = mag[W-1:0] << shamt;
      lost_bit = 1'b0;
    end
    sig    = moved[W-1 -: SIG_W];
    sticky = (|moved[DROP_W-1:0]) | lost_bit;
  end

endmodule

// File: rtl/norm_clamp.sv
`timescale 1ns/1ps
module norm_clamp
  import nrm_pkg::*;
#(
  parameter int EXP_W    = 10,
  parameter int MAG_W    = 16,
  parameter int FRAC_OUT = 8,
  parameter int EMIN     = -126
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sign,
  input  logic signed [EXP_W-1:0]   in_exp,
  input  logic [MAG_W-1:0]          in_mag,
  output logic                      out_valid,
  output logic                      out_sign,
  output logic signed [EXP_W-1:0]   out_exp,
  output logic [FRAC_OUT:0]         out_sig,
  output logic                      out_sticky
);

  localparam int W     = MAG_W - 1;
  localparam int SIG_W = FRAC_OUT + 1;
  localparam int CW    = $clog2(W + 1);

  logic [CW-1:0]           lead_zeros;
  logic [CW-1:0]           shamt;
  move_dir_e               dir;
  logic signed [EXP_W-1:0] exp_c;
  logic [SIG_W-1:0]        sig_c;
  logic                    sticky_c;
  logic                    mag_zero;

  assign mag_zero = (in_mag == '0);

  nrm_lzc #(.W(W), .CW(CW)) u_lzc (
    .vec   (in_mag[W-1:0]),
    .zeros (lead_zeros)
  );

  nrm_shamt #(.EXP_W(EXP_W), .CW(CW), .EMIN(EMIN)) u_shamt (
    .mag_big    (in_mag[MAG_W-1]),
    .mag_zero   (mag_zero),
    .exp_in     (in_exp),
    .lead_zeros (lead_zeros),
    .dir        (dir),
    .shamt      (shamt),
    .exp_out    (exp_c)
  );

  nrm_align #(.MAG_W(MAG_W), .SIG_W(SIG_W), .CW(CW)) u_align (
    .mag    (in_mag),
    .dir    (dir),
    .shamt  (shamt),
    .sig    (sig_c),
    .sticky (sticky_c)
  );

  // Next-state logic with the load enable written out.
  logic                    valid_d, sign_d, sticky_d;
  logic signed [EXP_W-1:0] exp_d;
  logic [SIG_W-1:0]        sig_d;

  always_comb begin
    valid_d  = in_valid;
    sign_d   = out_sign;
    exp_d    = out_exp;
    sig_d    = out_sig;
    sticky_d = out_sticky;
    if (in_valid) begin
      sign_d   = in_sign;
      exp_d    = exp_c;
      sig_d    = sig_c;
      sticky_d = sticky_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sign   <= 1'b0;
      out_exp    <= '0;
      out_sig    <= '0;
      out_sticky <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_sign   <= sign_d;
      out_exp    <= exp_d;
      out_sig    <= sig_d;
      out_sticky <= sticky_d;
    end
  end

endmodule

// File: rtl/norm_clamp_chk.sv
`timescale 1ns/1ps
module norm_clamp_chk #(
  parameter int EXP_W    = 10,
  parameter int MAG_W    = 16,
  parameter int FRAC_OUT = 8,
  parameter int EMIN     = -126
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [MAG_W-1:0]        in_mag,
  input logic                    out_valid,
  input logic                    out_sign,
  input logic signed [EXP_W-1:0] out_exp,
  input logic [FRAC_OUT:0]       out_sig,
  input logic                    out_sticky
);

  localparam logic signed [EXP_W-1:0] EMIN_V = EXP_W'(EMIN);

  // R2: a captured input produces a valid result on the next cycle.
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10: an idle cycle holds the data and drops valid.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sig) && $stable(out_exp)
                   && $stable(out_sticky) && $stable(out_sign)));

  // R4: a subnormal significand always comes with the floor exponent.
  a_r4_sub_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sig[FRAC_OUT]) |-> (out_exp == EMIN_V));

  // R3: the exponent never drops below the floor.
  a_r3_exp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp >= EMIN_V) |=> (out_exp >= EMIN_V));

  // R9: the sign passes through unchanged.
  a_r9_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sign == $past(in_sign)));

  // R8: a zero magnitude gives the floor exponent and clear outputs.
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mag == '0) |=> (out_sig == '0 && !out_sticky && out_exp == EMIN_V));

  // R6: a magnitude of two or more moves right by one place.
  a_r6_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mag[MAG_W-1]) |=>
      (out_exp == $past(in_exp) + EXP_W'(1) && out_sig[FRAC_OUT]
       && (out_sticky || !$past(in_mag[0]))));

endmodule

bind norm_clamp norm_clamp_chk #(
  .EXP_W(EXP_W), .MAG_W(MAG_W), .FRAC_OUT(FRAC_OUT), .EMIN(EMIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
  .in_exp(in_exp), .in_mag(in_mag), .out_valid(out_valid),
  .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
  .out_sticky(out_sticky)
);

// File: tb/norm_clamp_tb.sv
`timescale 1ns/1ps
module norm_clamp_tb;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_sign;
  logic signed [9:0] in_exp;
  logic [15:0]       in_mag;
  logic              out_valid, out_sign, out_sticky;
  logic signed [9:0] out_exp;
  logic [8:0]        out_sig;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  norm_clamp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mag(in_mag), .out_valid(out_valid),
    .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
    .out_sticky(out_sticky)
  );

  typedef struct packed {
    logic              s;
    logic [15:0]       mag;
    logic signed [9:0] e;
    logic signed [9:0] xe;
    logic [8:0]        xsig;
    logic              xst;
  } vec_t;

  // mag: [15:14] integer bits, [13:0] fraction; sig: [8] units bit, [7:0] fraction.
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h4000,  10'sd0,    10'sd0,    9'h100, 1'b0}, // 1.0
    '{1'b0, 16'h8000,  10'sd5,    10'sd6,    9'h100, 1'b0}, // 2.0, right
    '{1'b1, 16'hC001,  10'sd3,    10'sd4,    9'h180, 1'b1}, // right, lost bit
    '{1'b0, 16'h0400,  10'sd10,   10'sd6,    9'h100, 1'b0}, // left 4
    '{1'b0, 16'h0400, -10'sd124, -10'sd126,  9'h040, 1'b0}, // clamped at 2
    '{1'b0, 16'h4021, -10'sd3,   -10'sd3,    9'h100, 1'b1}, // low bits sticky
    '{1'b1, 16'h0000,  10'sd20,  -10'sd126,  9'h000, 1'b0}, // zero, sign kept
    '{1'b0, 16'h0001, -10'sd100, -10'sd114,  9'h100, 1'b0}, // left 14
    '{1'b0, 16'h0001, -10'sd120, -10'sd126,  9'h001, 1'b0}, // clamped at 6
    '{1'b1, 16'h0001, -10'sd126, -10'sd126,  9'h000, 1'b1}, // no room, sticky
    '{1'b0, 16'h1000, -10'sd124, -10'sd126,  9'h100, 1'b0}, // lz == headroom
    '{1'b0, 16'h2003, -10'sd125, -10'sd126,  9'h100, 1'b1}, // lz == headroom, sticky
    '{1'b0, 16'hFFFF, -10'sd126, -10'sd125,  9'h1FF, 1'b1}, // max magnitude
    '{1'b0, 16'h0013,  10'sd0,   -10'sd10,   9'h130, 1'b0}, // left 10, exact
    '{1'b0, 16'h0003, -10'sd126, -10'sd126,  9'h000, 1'b1}  // floor input, sub
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid = vld;
    in_sign  = v.s;
    in_exp   = v.e;
    in_mag   = v.mag;
  endtask

  task automatic expect_vec(input vec_t v);
    string cls;
    string ereq;
    cls  = v.xsig[8] ? "R3" : "R4";
    ereq = v.mag[15] ? "R6" : (v.mag == 16'h0 ? "R8" : "R5");
    check(out_valid == 1'b1, "R2", "valid", 32'(out_valid), 32'd1);
    check(out_sig == v.xsig, "R7", "significand", 32'(out_sig), 32'(v.xsig));
    check(out_sig[8] == v.xsig[8], cls, "units bit", 32'(out_sig[8]), 32'(v.xsig[8]));
    check(out_exp == v.xe, ereq, "exponent", 32'(out_exp), 32'(v.xe));
    check(out_sticky == v.xst, "R7", "sticky", 32'(out_sticky), 32'(v.xst));
    check(out_sign == v.s, "R9", "sign", 32'(out_sign), 32'(v.s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sign  = 1'b0;
    in_exp   = '0;
    in_mag   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'd0);
    check(out_sig == 9'h0 && out_sticky == 1'b0, "R1", "data in reset",
          32'({out_sig, out_sticky}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_exp == 10'sd0, "R1", "after release",
          32'({out_valid, out_exp}), 32'd0);

    // Table walk: drive on a falling edge, one rising edge, sample on the next falling edge.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      expect_vec(VEC[i]);
      in_valid = 1'b0;
      @(negedge clk);
    end

    // R10: idle cycle with changed data holds the last result.
    drive(VEC[2], 1'b1);
    @(negedge clk);
    drive(VEC[13], 1'b0);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid low when idle", 32'(out_valid), 32'd0);
    check(out_sig == VEC[2].xsig && out_exp == VEC[2].xe && out_sticky == VEC[2].xst,
          "R10", "held data", 32'({out_sig, out_exp, out_sticky}),
          32'({VEC[2].xsig, VEC[2].xe, VEC[2].xst}));

    // R2: back-to-back inputs, one result per cycle.
    drive(VEC[4], 1'b1);
    @(negedge clk);
    expect_vec(VEC[4]);
    drive(VEC[12], 1'b1);
    @(negedge clk);
    expect_vec(VEC[12]);
    drive(VEC[6], 1'b1);
    @(negedge clk);
    expect_vec(VEC[6]);
    in_valid = 1'b0;
    @(negedge clk);

    // R1: reset in mid-run clears the outputs.
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_sig == 9'h0 && out_exp == 10'sd0, "R1",
          "reset mid-run", 32'({out_valid, out_sig, out_exp}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule